// File: doc/BRIEF.md
# Packed Negated Multiply-Add Operand Router

This block sits in front of a row of 32-bit fused multiply-add lanes and turns them into a packed vector operation that computes "minus the product, plus an addend" in each lane. Each request carries three vectors: the destination, which is also a source, a second source and a third source. It also carries a form select that assigns these vectors to the lanes' multiplier and addend ports. The third source can be replaced by one 32-bit scalar that is broadcast to every lane. A vector-length select sets how many lanes are active. A per-lane write mask works in merge or zero mode, and two rounding-mode values are offered: an embedded one and a control-register one.

The lanes live outside this block. Each lane evaluates `-(x*y)+z` from the `lane_x`, `lane_y` and `lane_z` buses, using the rounding mode on `lane_rm`. It returns its result and exception flags in the same cycle. The router registers the routed operands when it accepts a request. It then applies masking and clears the bits above the active length, ORs together the flags of the lanes it writes, and returns the result with a one-cycle `done` pulse. It accepts one request every cycle.

Top module: `nfma_router`

## Requirements
- R1: Each lane computes `-(x*y)+z`. The `form` input maps the operands as follows. Form 0 gives x=dest, y=src3, z=src2. Form 1 gives x=src2, y=dest, z=src3. Form 2 gives x=src2, y=src3, z=dest. Lane j takes bits [32j+31:32j] of each vector.
- R2: The `vlen` input sets the active lane count: 0 gives 4 lanes, 1 gives 8 and 2 gives 16. The x, y and z buses of lanes at or above that count are driven to zero.
- R3: When `bbit`=1 and `src3_is_reg`=0 outside compact mode, every lane uses src3[31:0] in the role that R1 gives the third source. When `src3_is_reg`=1, each lane uses its own src3 slice.
- R4: An active lane is written with its lane result when masking is off (`mask_en`=0) or when its `kmask` bit is 1.
- R5: An active lane whose mask bit is 0 while masking is on keeps its old dest value when `zero_mode`=0, and becomes zero when `zero_mode`=1.
- R6: Every result bit at or above 32 times the active lane count reads zero.
- R7: `lane_rm` carries `rc_embed` only when compact mode is off, `vlen`=2, `bbit`=1 and `src3_is_reg`=1. In every other case it carries `rc_ctl`.
- R8: With `legacy_mode`=1, only `vlen` 0 and 1 are legal. In this mode `kmask`, `mask_en`, `zero_mode` and `bbit` have no effect: every active lane is written, no broadcast occurs, `lane_rm` carries `rc_ctl`, and the upper bits are zeroed.
- R9: `flags` is the OR of the lane flag fields of the lanes that are written. Lanes that are masked off or out of range contribute nothing.
- R10: During reset, `in_ready`, `done`, `result` and `flags` are 0, and `in_ready` is 1 from the first cycle after reset. A request is accepted at an edge where `in_valid` and `in_ready` are both high. Its lane operands appear after that edge, and `done`, `result` and `flags` appear one edge later. Back-to-back requests give back-to-back `done` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| form | input | 2 | Operand assignment form (0, 1, 2) |
| vlen | input | 2 | Active length: 0=4, 1=8, 2=16 lanes |
| legacy_mode | input | 1 | Compact encoding without masking or broadcast |
| bbit | input | 1 | Broadcast (memory source) or rounding override (register source) |
| src3_is_reg | input | 1 | Third source comes from a register |
| mask_en | input | 1 | Write masking active |
| zero_mode | input | 1 | Masked lanes are cleared instead of kept |
| kmask | input | LANES | Per-lane write mask |
| rc_embed | input | RM_W | Rounding mode carried with the request |
| rc_ctl | input | RM_W | Rounding mode from the control register |
| dst_vec | input | LANES*32 | Destination and source vector |
| src2_vec | input | LANES*32 | Second source vector |
| src3_vec | input | LANES*32 | Third source vector or scalar in the low lane |
| lane_x | output | LANES*32 | Per-lane first multiplier operand |
| lane_y | output | LANES*32 | Per-lane second multiplier operand |
| lane_z | output | LANES*32 | Per-lane addend |
| lane_rm | output | RM_W | Rounding mode for all lanes |
| lane_res | input | LANES*32 | Lane results, same cycle as operands |
| lane_flags | input | LANES*FLAG_W | Lane exception flags |
| done | output | 1 | Result valid pulse |
| result | output | LANES*32 | Merged destination vector |
| flags | output | FLAG_W | OR of flags from written lanes |

## Verification
The assertions assume that requests never use the reserved form code 3 or the reserved length code 3, and that compact mode never asks for 16 lanes. They also assume the lane results depend only on the lane operand buses of the same cycle. The stimulus sweeps every legal combination of form, length, mode, broadcast bit, source kind, masking and merge/zero mode, and skips the illegal compact/16-lane pairing. A stand-in lane model that is not symmetric in its three operands makes any mix-up of operand roles visible in the result. That model also gives nonzero flags and results on unused lanes, so leakage from masked or out-of-range lanes shows at the ports.

// File: rtl/nfma_pkg.sv
package nfma_pkg;
  localparam int unsigned LANE_W = 32;

  typedef enum logic [1:0] {
    FORM_132  = 2'd0,
    FORM_213  = 2'd1,
    FORM_231  = 2'd2,
    FORM_RSVD = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    LEN_128  = 2'd0,
    LEN_256  = 2'd1,
    LEN_512  = 2'd2,
    LEN_RSVD = 2'd3
  } vlen_e;

  typedef struct packed {
    logic [LANE_W-1:0] mul_x;
    logic [LANE_W-1:0] mul_y;
    logic [LANE_W-1:0] add_z;
  } lane_ops_t;

  // number of active lanes for a length code
  function automatic logic [5:0] lane_limit(input logic [1:0] vlen);
    return 6'd4 << vlen;
  endfunction

  // operand role assignment per form; lane computes -(x*y)+z
  function automatic lane_ops_t route_ops(input logic [1:0] form,
                                          input logic [LANE_W-1:0] dst,
                                          input logic [LANE_W-1:0] s2,
                                          input logic [LANE_W-1:0] s3);
    lane_ops_t o;
    case (form)
      FORM_132: o = '{mul_x: dst, mul_y: s3,  add_z: s2};
      FORM_213: o = '{mul_x: s2,  mul_y: dst, add_z: s3};
      FORM_231: o = '{mul_x: s2,  mul_y: s3,  add_z: dst};
      default:  o = '0;
    endcase
    return o;
  endfunction

  // final value of one lane after masking
  function automatic logic [LANE_W-1:0] pick_lane(input logic wr,
                                                  input logic active,
                                                  input logic zero,
                                                  input logic [LANE_W-1:0] res,
                                                  input logic [LANE_W-1:0] old);
    if (wr)                return res;
    else if (active && !zero) return old;
    else                   return '0;
  endfunction
endpackage

// File: rtl/nfma_lane_ctrl.sv
module nfma_lane_ctrl
  import nfma_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned RM_W  = 2
) (
  input  logic [1:0]       vlen,
  input  logic             legacy_mode,
  input  logic             bbit,
  input  logic             src3_is_reg,
  input  logic             mask_en,
  input  logic [LANES-1:0] kmask,
  input  logic [RM_W-1:0]  rc_embed,
  input  logic [RM_W-1:0]  rc_ctl,
  output logic [LANES-1:0] in_range,
  output logic [LANES-1:0] wr_en,
  output logic             bcast_eff,
  output logic             rm_override,
  output logic [RM_W-1:0]  rm_sel
);
  logic [5:0] limit;
  logic       masking_on;

  assign limit      = lane_limit(vlen);
  assign masking_on = mask_en && !legacy_mode;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign in_range[j] = (6'(j) < limit);
    assign wr_en[j]    = in_range[j] && (!masking_on || kmask[j]);
  end

  // the b bit means broadcast on a memory source, rounding override on a register source
  assign bcast_eff   = bbit && !src3_is_reg && !legacy_mode;
  assign rm_override = bbit && src3_is_reg && !legacy_mode && (vlen == LEN_512);
  assign rm_sel      = rm_override ? rc_embed : rc_ctl;
endmodule

// File: rtl/nfma_operand_mux.sv
module nfma_operand_mux
  import nfma_pkg::*;
#(
  parameter int unsigned LANES = 16
) (
  input  logic [1:0]              form,
  input  logic                    bcast,
  input  logic [LANES-1:0]        in_range,
  input  logic [LANES*LANE_W-1:0] dst_vec,
  input  logic [LANES*LANE_W-1:0] src2_vec,
  input  logic [LANES*LANE_W-1:0] src3_vec,
  output logic [LANES*LANE_W-1:0] x_vec,
  output logic [LANES*LANE_W-1:0] y_vec,
  output logic [LANES*LANE_W-1:0] z_vec
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] s3_lane;
    lane_ops_t         ops;

    assign s3_lane = bcast ? src3_vec[LANE_W-1:0] : src3_vec[j*LANE_W +: LANE_W];
    assign ops     = route_ops(form, dst_vec[j*LANE_W +: LANE_W],
                               src2_vec[j*LANE_W +: LANE_W], s3_lane);

    // idle lanes see zero operands
    assign x_vec[j*LANE_W +: LANE_W] = in_range[j] ? ops.mul_x : '0;
    assign y_vec[j*LANE_W +: LANE_W] = in_range[j] ? ops.mul_y : '0;
    assign z_vec[j*LANE_W +: LANE_W] = in_range[j] ? ops.add_z : '0;
  end
endmodule

// File: rtl/nfma_writeback.sv
module nfma_writeback
  import nfma_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned FLAG_W = 5
) (
  input  logic [LANES-1:0]        wr_en,
  input  logic [LANES-1:0]        in_range,
  input  logic                    zero_mode,
  input  logic [LANES*LANE_W-1:0] old_vec,
  input  logic [LANES*LANE_W-1:0] res_vec,
  input  logic [LANES*FLAG_W-1:0] lane_flags,
  output logic [LANES*LANE_W-1:0] out_vec,
  output logic [FLAG_W-1:0]       flags_or
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign out_vec[j*LANE_W +: LANE_W] =
      pick_lane(wr_en[j], in_range[j], zero_mode,
                res_vec[j*LANE_W +: LANE_W], old_vec[j*LANE_W +: LANE_W]);
  end

  always_comb begin
    flags_or = '0;
    for (int j = 0; j < LANES; j++) begin
      if (wr_en[j]) flags_or = flags_or | lane_flags[j*FLAG_W +: FLAG_W];
    end
  end
endmodule

// File: rtl/nfma_router.sv
module nfma_router
  import nfma_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned FLAG_W = 5,
  parameter int unsigned RM_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              form,
  input  logic [1:0]              vlen,
  input  logic                    legacy_mode,
  input  logic                    bbit,
  input  logic                    src3_is_reg,
  input  logic                    mask_en,
  input  logic                    zero_mode,
  input  logic [LANES-1:0]        kmask,
  input  logic [RM_W-1:0]         rc_embed,
  input  logic [RM_W-1:0]         rc_ctl,
  input  logic [LANES*LANE_W-1:0] dst_vec,
  input  logic [LANES*LANE_W-1:0] src2_vec,
  input  logic [LANES*LANE_W-1:0] src3_vec,
  output logic [LANES*LANE_W-1:0] lane_x,
  output logic [LANES*LANE_W-1:0] lane_y,
  output logic [LANES*LANE_W-1:0] lane_z,
  output logic [RM_W-1:0]         lane_rm,
  input  logic [LANES*LANE_W-1:0] lane_res,
  input  logic [LANES*FLAG_W-1:0] lane_flags,
  output logic                    done,
  output logic [LANES*LANE_W-1:0] result,
  output logic [FLAG_W-1:0]       flags
);
  localparam int unsigned VW = LANES * LANE_W;

  // named events for assertions
  logic             accept;
  logic [LANES-1:0] c_in_range, c_wr_en;
  logic             c_bcast, c_rm_override;
  logic [RM_W-1:0]  c_rm;
  logic [VW-1:0]    c_x, c_y, c_z;

  // stage-1 state (operands presented to lanes)
  logic             s1_valid;
  logic [LANES-1:0] s1_inr, s1_wen;
  logic             s1_zero;
  logic [VW-1:0]    s1_old;

  logic [VW-1:0]       wb_vec;
  logic [FLAG_W-1:0]   wb_flags;

  assign accept = in_valid && in_ready;

  nfma_lane_ctrl #(.LANES(LANES), .RM_W(RM_W)) u_ctrl (
    .vlen        (vlen),
    .legacy_mode (legacy_mode),
    .bbit        (bbit),
    .src3_is_reg (src3_is_reg),
    .mask_en     (mask_en),
    .kmask       (kmask),
    .rc_embed    (rc_embed),
    .rc_ctl      (rc_ctl),
    .in_range    (c_in_range),
    .wr_en       (c_wr_en),
    .bcast_eff   (c_bcast),
    .rm_override (c_rm_override),
    .rm_sel      (c_rm)
  );

  nfma_operand_mux #(.LANES(LANES)) u_mux (
    .form     (form),
    .bcast    (c_bcast),
    .in_range (c_in_range),
    .dst_vec  (dst_vec),
    .src2_vec (src2_vec),
    .src3_vec (src3_vec),
    .x_vec    (c_x),
    .y_vec    (c_y),
    .z_vec    (c_z)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      s1_valid <= 1'b0;
      s1_inr   <= '0;
      s1_wen   <= '0;
      s1_zero  <= 1'b0;
      s1_old   <= '0;
      lane_x   <= '0;
      lane_y   <= '0;
      lane_z   <= '0;
      lane_rm  <= '0;
    end else begin
      in_ready <= 1'b1;
      s1_valid <= accept;
      if (accept) begin
        s1_inr  <= c_in_range;
        s1_wen  <= c_wr_en;
        s1_zero <= zero_mode && !legacy_mode;
        s1_old  <= dst_vec;
        lane_x  <= c_x;
        lane_y  <= c_y;
        lane_z  <= c_z;
        lane_rm <= c_rm;
      end
    end
  end

  nfma_writeback #(.LANES(LANES), .FLAG_W(FLAG_W)) u_wb (
    .wr_en      (s1_wen),
    .in_range   (s1_inr),
    .zero_mode  (s1_zero),
    .old_vec    (s1_old),
    .res_vec    (lane_res),
    .lane_flags (lane_flags),
    .out_vec    (wb_vec),
    .flags_or   (wb_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      flags  <= '0;
    end else begin
      done <= s1_valid;
      if (s1_valid) begin
        result <= wb_vec;
        flags  <= wb_flags;
      end
    end
  end

  // ---------------- assertions ----------------
  p_form_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (form != FORM_RSVD));

  p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((vlen != LEN_RSVD) && !(legacy_mode && vlen == LEN_512)));

  p_rm_ctl_in_legacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legacy_mode) |=> (lane_rm == $past(rc_ctl)));

  p_rm_embed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !legacy_mode && bbit && src3_is_reg && vlen == LEN_512) |=> (lane_rm == $past(rc_embed)));

  p_done_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 done);

  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept, 2));

  p_flags_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !legacy_mode && mask_en && kmask == '0) |=> ##1 (flags == '0));

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    p_idle_ops_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_inr[j]) |->
        (lane_x[j*LANE_W +: LANE_W] == '0 && lane_y[j*LANE_W +: LANE_W] == '0 &&
         lane_z[j*LANE_W +: LANE_W] == '0));

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(s1_inr[j])) |-> (result[j*LANE_W +: LANE_W] == '0));

    p_merge_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(s1_inr[j] && !s1_wen[j] && !s1_zero)) |->
        (result[j*LANE_W +: LANE_W] == $past(s1_old[j*LANE_W +: LANE_W])));
  end
endmodule

// File: tb/nfma_router_test.sv
module nfma_router_test;
  localparam int N  = 16;
  localparam int MW = N * 32;
  localparam int FW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    form = '0, vlen = '0;
  logic          legacy_mode = 1'b0, bbit = 1'b0, src3_is_reg = 1'b0;
  logic          mask_en = 1'b0, zero_mode = 1'b0;
  logic [N-1:0]  kmask = '0;
  logic [1:0]    rc_embed = '0, rc_ctl = '0;
  logic [MW-1:0] dst_vec = '0, src2_vec = '0, src3_vec = '0;
  logic [MW-1:0] lane_x, lane_y, lane_z, lane_res, result;
  logic [1:0]    lane_rm;
  logic [N*FW-1:0] lane_flags;
  logic          done;
  logic [FW-1:0] flags;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nfma_router #(.LANES(N), .FLAG_W(FW), .RM_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .form(form), .vlen(vlen), .legacy_mode(legacy_mode), .bbit(bbit),
    .src3_is_reg(src3_is_reg), .mask_en(mask_en), .zero_mode(zero_mode),
    .kmask(kmask), .rc_embed(rc_embed), .rc_ctl(rc_ctl),
    .dst_vec(dst_vec), .src2_vec(src2_vec), .src3_vec(src3_vec),
    .lane_x(lane_x), .lane_y(lane_y), .lane_z(lane_z), .lane_rm(lane_rm),
    .lane_res(lane_res), .lane_flags(lane_flags),
    .done(done), .result(result), .flags(flags)
  );

  // stand-in lanes: asymmetric in x, y, z so swapped roles show up
  function automatic logic [31:0] mdl_res(input logic [31:0] x, input logic [31:0] y, input logic [31:0] z);
    return (x * 32'd3) ^ {y[15:0], y[31:16]} ^ (z + 32'h9e37_79b9);
  endfunction

  function automatic logic [FW-1:0] mdl_flg(input logic [31:0] x, input logic [31:0] y, input logic [31:0] z);
    logic [31:0] t;
    t = x ^ {y[30:0], y[31]} ^ (z >> 3);
    return t[FW-1:0] ^ 5'h11;
  endfunction

  always_comb begin
    for (int j = 0; j < N; j++) begin
      lane_res[j*32 +: 32]   = mdl_res(lane_x[j*32 +: 32], lane_y[j*32 +: 32], lane_z[j*32 +: 32]);
      lane_flags[j*FW +: FW] = mdl_flg(lane_x[j*32 +: 32], lane_y[j*32 +: 32], lane_z[j*32 +: 32]);
    end
  end

  task automatic check(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_op(input logic [1:0] f, input logic [1:0] vl, input logic lg, input logic bb,
                           input logic sr, input logic me, input logic zm, input logic [N-1:0] km,
                           input logic [MW-1:0] d, input logic [MW-1:0] s2, input logic [MW-1:0] s3,
                           input logic [1:0] ce, input logic [1:0] cc,
                           output logic [MW-1:0] ex, output logic [MW-1:0] ey, output logic [MW-1:0] ez,
                           output logic [MW-1:0] er, output logic [FW-1:0] ef, output logic [1:0] erm);
    int cnt;
    logic bc;
    logic [31:0] t3, a, b, c, dj, s2j;
    cnt = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    bc  = bb && !sr && !lg;
    ex = '0; ey = '0; ez = '0; er = '0; ef = '0;
    for (int j = 0; j < N; j++) begin
      if (j < cnt) begin
        t3  = bc ? s3[31:0] : s3[j*32 +: 32];
        dj  = d[j*32 +: 32];
        s2j = s2[j*32 +: 32];
        if (f == 2'd0)      begin a = dj;  b = t3; c = s2j; end
        else if (f == 2'd1) begin a = s2j; b = dj; c = t3;  end
        else                begin a = s2j; b = t3; c = dj;  end
        ex[j*32 +: 32] = a;
        ey[j*32 +: 32] = b;
        ez[j*32 +: 32] = c;
        if (lg || !me || km[j]) begin
          er[j*32 +: 32] = mdl_res(a, b, c);
          ef = ef | mdl_flg(a, b, c);
        end else begin
          er[j*32 +: 32] = zm ? 32'd0 : dj;
        end
      end
    end
    erm = (!lg && vl == 2'd2 && bb && sr) ? ce : cc;
  endtask

  task automatic drive(input logic [1:0] f, input logic [1:0] vl, input logic lg, input logic bb,
                       input logic sr, input logic me, input logic zm, input logic [N-1:0] km,
                       input logic [MW-1:0] d, input logic [MW-1:0] s2, input logic [MW-1:0] s3,
                       input logic [1:0] ce, input logic [1:0] cc);
    form = f; vlen = vl; legacy_mode = lg; bbit = bb; src3_is_reg = sr;
    mask_en = me; zero_mode = zm; kmask = km;
    dst_vec = d; src2_vec = s2; src3_vec = s3; rc_embed = ce; rc_ctl = cc;
    in_valid = 1'b1;
  endtask

  task automatic fill(output logic [MW-1:0] d, output logic [MW-1:0] s2, output logic [MW-1:0] s3,
                      output logic [1:0] ce, output logic [1:0] cc);
    for (int j = 0; j < N; j++) begin
      d[j*32 +: 32]  = $urandom;
      s2[j*32 +: 32] = $urandom;
      s3[j*32 +: 32] = $urandom;
    end
    ce = 2'($urandom);
    cc = 2'($urandom);
    if (ce == cc) ce = ~cc;
  endtask

  task automatic run_op(input logic [1:0] f, input logic [1:0] vl, input logic lg, input logic bb,
                        input logic sr, input logic me, input logic zm, input logic [N-1:0] km);
    logic [MW-1:0] d, s2, s3, ex, ey, ez, er;
    logic [FW-1:0] ef;
    logic [1:0]    ce, cc, erm;
    fill(d, s2, s3, ce, cc);
    expect_op(f, vl, lg, bb, sr, me, zm, km, d, s2, s3, ce, cc, ex, ey, ez, er, ef, erm);
    @(negedge clk);
    drive(f, vl, lg, bb, sr, me, zm, km, d, s2, s3, ce, cc);
    @(negedge clk);
    in_valid = 1'b0;
    check(lg ? "R8 R1 R2 lane x operands" : "R1 R2 R3 lane x operands", lane_x, ex);
    check(lg ? "R8 R1 R2 lane y operands" : "R1 R2 R3 lane y operands", lane_y, ey);
    check(lg ? "R8 R1 R2 lane z operands" : "R1 R2 R3 lane z operands", lane_z, ez);
    check(lg ? "R8 rounding select" : "R7 rounding select", MW'(lane_rm), MW'(erm));
    @(negedge clk);
    check("R10 done pulse", MW'(done), MW'(1'b1));
    check(lg ? "R8 R4 R6 result" : "R4 R5 R6 result", result, er);
    check("R9 flags", MW'(flags), MW'(ef));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int idx;
    logic [N-1:0] km;
    logic [MW-1:0] d, s2, s3, exa, eya, eza, era, exb, eyb, ezb, erb;
    logic [FW-1:0] efa, efb;
    logic [1:0] ce, cc, erma, ermb, ce2, cc2;
    logic [MW-1:0] d2, s22, s32;
    idx = 0;
    void'($urandom(32'd7));

    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 reset in_ready", MW'(in_ready), '0);
    check("R10 reset done", MW'(done), '0);
    check("R10 reset result", result, '0);
    check("R10 reset flags", MW'(flags), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", MW'(in_ready), MW'(1'b1));

    // near-exhaustive sweep over all legal control combinations
    for (int f = 0; f < 3; f++)
      for (int lg = 0; lg < 2; lg++)
        for (int vl = 0; vl < 3; vl++)
          for (int bb = 0; bb < 2; bb++)
            for (int sr = 0; sr < 2; sr++)
              for (int me = 0; me < 2; me++)
                for (int zm = 0; zm < 2; zm++) begin
                  if (lg == 1 && vl == 2) continue;
                  case (idx % 4)
                    0: km = '0;
                    1: km = '1;
                    2: km = 16'h5a3c;
                    default: km = N'($urandom);
                  endcase
                  idx++;
                  run_op(2'(f), 2'(vl), 1'(lg), 1'(bb), 1'(sr), 1'(me), 1'(zm), km);
                end

    // R10 back-to-back acceptance
    fill(d, s2, s3, ce, cc);
    expect_op(2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0ff0, d, s2, s3, ce, cc,
              exa, eya, eza, era, efa, erma);
    fill(d2, s22, s32, ce2, cc2);
    expect_op(2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h00a5, d2, s22, s32, ce2, cc2,
              exb, eyb, ezb, erb, efb, ermb);
    @(negedge clk);
    drive(2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0ff0, d, s2, s3, ce, cc);
    @(negedge clk);
    drive(2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h00a5, d2, s22, s32, ce2, cc2);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 first of pair done", MW'(done), MW'(1'b1));
    check("R10 first of pair result", result, era);
    @(negedge clk);
    check("R10 second of pair done", MW'(done), MW'(1'b1));
    check("R10 second of pair result", result, erb);
    check("R9 second of pair flags", MW'(flags), MW'(efb));
    @(negedge clk);
    check("R10 done drops after pair", MW'(done), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule